// File: doc/BRIEF.md
# Bidirectional Gray-Code Step Counter

This block is a synchronous counter whose registered value always holds a reflected Gray code. On every clock it moves one position through the Gray cycle. A direction input chooses forward or backward motion. Because neighbouring codes differ in a single bit, the value can be sampled safely by logic in another timing domain, and it never shows the multi-bit glitches of a binary count.

The direction input is sampled at every rising edge, so the traversal can turn around on any cycle. A synchronous reset returns the count to all zeros. A terminal flag marks the last code before the cycle wraps in the direction currently selected. The code width is a parameter with a default of three bits. The whole block is one state register and the logic that computes its next value.

Top module: `gray_step_ctr`

## Requirements
- R1: When `srst` is 1 at a rising edge, `code_o` becomes 000 after that edge, whatever the value of `dir_up`.
- R2: With `srst` = 0 and `dir_up` = 1 at an edge, `code_o` advances along 000, 001, 011, 010, 110, 111, 101, 100 and wraps from 100 to 000.
- R3: With `srst` = 0 and `dir_up` = 0 at an edge, `code_o` moves along the same cycle in reverse: 000 to 100, 100 to 101, and so on down to 001 to 000.
- R4: Every non-reset step changes exactly one bit of `code_o`, and this includes the wrap in either direction.
- R5: The direction can change on any cycle. Each step uses the `dir_up` value sampled at that same edge, and the value from earlier cycles has no effect.
- R6: `term_o` is 1 exactly when `code_o` is 100 with `dir_up` = 1, or when `code_o` is 000 with `dir_up` = 0. It is 0 in every other case.
- R7: A full run of 8 steps in one direction returns `code_o` to the code it started from. No code repeats within those 8 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| dir_up | input | 1 | 1 = forward through the cycle, 0 = backward |
| code_o | output | 3 | Registered Gray code state |
| term_o | output | 1 | Last code before the wrap in the selected direction |

## Verification
The hardest cases to reach are a direction reversal on exactly the cycle where the count sits on a wrap code, and a reset while the direction is still toggling. In both, a wrong choice of which `dir_up` sample to use, or a wrong reset priority, shows only for one cycle. The stimulus first parks the counter on 000 and on 100 and flips the direction there. It then toggles `dir_up` on every cycle, and finally runs a long pseudo-random mix of direction and occasional reset. A queue-based model checks the state and the flag on every clock.

// File: rtl/gray_step_pkg.sv
package gray_step_pkg;

    typedef enum logic {
        DIR_BACK = 1'b0,
        DIR_FWD  = 1'b1
    } step_dir_e;

endpackage

// File: rtl/gray_step_next.sv
module gray_step_next #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0]          cur_i,
    input  gray_step_pkg::step_dir_e  dir_i,
    output logic [WIDTH-1:0]          nxt_o
);
    logic [WIDTH-1:0] ord_w;
    logic [WIDTH-1:0] ord_step_w;

    // Gray to ordinal: a running XOR from the top bit down
    assign ord_w[WIDTH-1] = cur_i[WIDTH-1];
    generate
        for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_ord
            assign ord_w[i] = ord_w[i+1] ^ cur_i[i];
        end
    endgenerate

    always_comb begin
        if (dir_i == gray_step_pkg::DIR_FWD) begin
            ord_step_w = ord_w + WIDTH'(1);
        end else begin
            ord_step_w = ord_w - WIDTH'(1);
        end
    end

    // ordinal back to reflected Gray
    assign nxt_o = ord_step_w ^ (ord_step_w >> 1);
endmodule

// File: rtl/gray_step_term.sv
module gray_step_term #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0]          cur_i,
    input  gray_step_pkg::step_dir_e  dir_i,
    output logic                      term_o
);
    localparam logic [WIDTH-1:0] LAST_FWD  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] LAST_BACK = '0;

    always_comb begin
        if (dir_i == gray_step_pkg::DIR_FWD) begin
            term_o = (cur_i == LAST_FWD);
        end else begin
            term_o = (cur_i == LAST_BACK);
        end
    end
endmodule

// File: rtl/gray_step_ctr.sv
module gray_step_ctr #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             dir_up,
    output logic [WIDTH-1:0] code_o,
    output logic             term_o
);
    typedef struct packed {
        logic [WIDTH-1:0] code;
    } ctr_state_t;

    ctr_state_t               st_d;
    ctr_state_t               st_q;
    gray_step_pkg::step_dir_e dir_w;
    logic [WIDTH-1:0]         step_w;

    assign dir_w = gray_step_pkg::step_dir_e'(dir_up);

    gray_step_next #(.WIDTH(WIDTH)) u_next (
        .cur_i (st_q.code),
        .dir_i (dir_w),
        .nxt_o (step_w)
    );

    gray_step_term #(.WIDTH(WIDTH)) u_term (
        .cur_i  (st_q.code),
        .dir_i  (dir_w),
        .term_o (term_o)
    );

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.code = '0;
        end else begin
            st_d.code = step_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/gray_step_chk.sv
module gray_step_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             srst,
    input logic             dir_up,
    input logic [WIDTH-1:0] code_o,
    input logic             term_o
);
    logic             armed_q  = 1'b0;
    logic             armed2_q = 1'b0;
    logic             rst_d1_q = 1'b0;
    logic             dir_d1_q = 1'b0;
    logic [WIDTH-1:0] prev_q   = '0;

    function automatic logic [WIDTH-1:0] to_ord(input logic [WIDTH-1:0] g);
        logic [WIDTH-1:0] r;
        r = '0;
        for (int k = 0; k < WIDTH; k++) begin
            r = r ^ (g >> k);
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        armed_q  <= armed_q | srst;
        armed2_q <= armed_q;
        rst_d1_q <= srst;
        dir_d1_q <= dir_up;
        prev_q   <= code_o;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (srst)
        rst_d1_q |-> (code_o == '0)) else $error("reset value"); // R1

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (srst)
        (armed2_q && !rst_d1_q && dir_d1_q) |->
        (to_ord(code_o) == to_ord(prev_q) + WIDTH'(1))) else $error("fwd step"); // R2

    AST_BACK_STEP: assert property (@(posedge clk) disable iff (srst)
        (armed2_q && !rst_d1_q && !dir_d1_q) |->
        (to_ord(code_o) == to_ord(prev_q) - WIDTH'(1))) else $error("back step"); // R3

    AST_ONE_BIT: assert property (@(posedge clk) disable iff (srst)
        (armed2_q && !rst_d1_q) |-> ($countones(code_o ^ prev_q) == 1)) else $error("bit count"); // R4

    AST_TERM_WRAP: assert property (@(posedge clk) disable iff (srst)
        (armed_q && term_o && dir_up) |=> (code_o == '0)) else $error("fwd wrap"); // R6
endmodule

bind gray_step_ctr gray_step_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .srst   (srst),
    .dir_up (dir_up),
    .code_o (code_o),
    .term_o (term_o)
);

// File: tb/sim_gray_step_ctr.sv
module sim_gray_step_ctr;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       dir_up = 1'b0;
    logic [2:0] code_o;
    logic       term_o;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    int start_pos = 0;
    logic [2:0] last_code = 3'b000;
    logic       last_dir = 1'b0;
    logic       was_rst = 1'b1;
    int lfsr = 32'h1ACE;
    bit done = 1'b0;
    logic [2:0] ring[$] = '{3'b000, 3'b001, 3'b011, 3'b010,
                            3'b110, 3'b111, 3'b101, 3'b100};

    always #10 clk = ~clk;

    gray_step_ctr u0 (
        .clk    (clk),
        .srst   (srst),
        .dir_up (dir_up),
        .code_o (code_o),
        .term_o (term_o)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, then compare at the following falling edge
    task automatic cyc(input logic r, input logic d);
        logic       exp_term;
        logic [2:0] prev_code;
        logic       dir_changed;
        prev_code   = code_o;
        dir_changed = (d != last_dir);
        srst   = r;
        dir_up = d;
        if (r) pos = 0;
        else if (d) pos = (pos + 1) % 8;
        else pos = (pos + 7) % 8;
        @(negedge clk);
        exp_term = (d && ring[pos] == 3'b100) || (!d && ring[pos] == 3'b000);
        if (r) check("R1", code_o, 3'b000);
        else if (dir_changed) check("R5", code_o, ring[pos]);
        else if (d) check("R2", code_o, ring[pos]);
        else check("R3", code_o, ring[pos]);
        check("R6", {2'b00, term_o}, {2'b00, exp_term});
        if (!r && !was_rst) begin
            checks++;
            if ($countones(code_o ^ prev_code) != 1) begin
                errors++;
                $display("FAIL R4 actual %b expected one-bit change from %b", code_o, prev_code);
            end
        end
        last_dir  = d;
        was_rst   = r;
        last_code = code_o;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cyc(1'b1, 1'b1);
        check("R1", code_o, 3'b000);
        cyc(1'b1, 1'b0);
        // forward full lap and back to start
        start_pos = 0;
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1);
        check("R7", code_o, ring[start_pos]);
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1);
        // backward full lap
        start_pos = pos;
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0);
        check("R7", code_o, ring[start_pos]);
        for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0);
        // park on 000, then reverse exactly on the wrap codes
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        // toggle every cycle
        for (int i = 0; i < 16; i++) cyc(1'b0, i[0]);
        // reset with changing direction
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        // pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            cyc((lfsr % 29) == 0, lfsr[3]);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule